// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline (fetch, decode with register read, execute, data memory access, write-back) can advance, and where the execute-stage ALU takes its operands from. It reads the valid bit, the instruction class and the register indices of the instructions that sit in decode, execute, memory access and write-back. From these it drives a hold for the fetch and decode pipeline registers, a bubble into execute, and a 2-bit source select for each ALU operand. The logic is purely combinational. The clock and reset inputs only time the embedded property checks.

ALU operands may be bypassed from the memory-access boundary or from the write-back boundary. A store is handled differently: the value it writes to memory must be the one read from the register file in decode. A store whose data register is still being produced therefore waits in decode until the producer reaches write-back, since the register file writes early in the cycle. A load result exists only at the end of memory access, so an instruction that needs it right away loses one cycle in decode.

Top module: `hfc_top`

## Requirements
- R1: Whenever the block holds decode, `stall_fetch`, `stall_decode` and `bubble_ex` are all high in that same cycle. When it does not hold decode, all three are low, and they are low while reset is applied with all stages invalid.
- R2: An ALU-class producer one stage ahead of its consumer (the producer in memory access, the consumer in execute) causes no stall, and the consumer's operand select is 01 (bypass from memory stage).
- R3: A producer of ALU or load class in write-back that matches an execute-stage operand gives that operand select 10 (bypass from write-back).
- R4: A decode instruction that reads the destination of a load currently in execute stalls for exactly one cycle. This applies to operand A for ALU, load and store, and to operand B for ALU. Once the load reaches write-back, the operand select is 10.
- R5: A store in decode stalls while its data register (operand B index) matches the destination of a valid ALU or load instruction in execute or memory access. It does not stall once that producer is in write-back. For a store in execute, `sel_b` is always 00.
- R6: When both the memory-stage and the write-back-stage producers match an operand, the memory-stage producer wins (select 01).
- R7: With register 0 hardwired to zero (default), index 0 never produces a bypass and never causes a stall.
- R8: Class codes are 00 other, 01 ALU, 10 load, 11 store. Select codes are 00 register file, 01 memory stage, 10 write-back. The code 11 is never driven.
- R9: For the sequence load r1, then r1 = r1 + r1, then r2 = r2 - r1, the third instruction is in write-back in cycle 8, counting the fetch of the first as cycle 1, with exactly one stall cycle.
- R10: A store's address register (operand A) may be bypassed into execute, so an ALU result feeding a store address causes no stall.
- R11: Entries whose valid bit is 0, and instructions of class other, never cause a stall or a bypass, whatever their register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_class | input | 2 | Decode instruction class |
| dec_src_a | input | IDX_W | Decode operand A register index |
| dec_src_b | input | IDX_W | Decode operand B / store data register index |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_class | input | 2 | Execute instruction class |
| ex_dest | input | IDX_W | Execute destination register index |
| ex_src_a | input | IDX_W | Execute operand A register index |
| ex_src_b | input | IDX_W | Execute operand B register index |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_class | input | 2 | Memory-stage instruction class |
| mem_dest | input | IDX_W | Memory-stage destination register index |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_class | input | 2 | Write-back instruction class |
| wb_dest | input | IDX_W | Write-back destination register index |
| stall_fetch | output | 1 | Hold the fetch pipeline register |
| stall_decode | output | 1 | Hold the decode pipeline register |
| bubble_ex | output | 1 | Load an invalid entry into execute |
| sel_a | output | 2 | Operand A source select for the ALU |
| sel_b | output | 2 | Operand B source select for the ALU |

## Verification
The bench builds the block with its defaults: 5-bit register indices, register 0 hardwired to zero, and bypassing enabled. With these values the zero-register exemption, the priority between the two bypass sources and the split between the ALU and store-data hazard paths are all reachable. The bench replays short dependent sequences through a behavioural pipeline model. Stall bubbles carry stale register fields, which exercises the valid-bit qualification. The total cycle and stall counts are checked against the hand-derived figures.

// File: rtl/hfc_pkg.sv
package hfc_pkg;

   typedef enum logic [1:0] {
      CLS_OTHER = 2'b00,
      CLS_ALU   = 2'b01,
      CLS_LOAD  = 2'b10,
      CLS_STORE = 2'b11
   } op_cls_e;

   typedef enum logic [1:0] {
      SEL_REGFILE  = 2'b00,
      SEL_FROM_MEM = 2'b01,
      SEL_FROM_WB  = 2'b10
   } opnd_sel_e;

   function automatic logic cls_writes_reg(op_cls_e c);
      return (c == CLS_ALU) || (c == CLS_LOAD);
   endfunction

   function automatic logic cls_reads_a(op_cls_e c);
      return c != CLS_OTHER;
   endfunction

   function automatic logic cls_reads_b(op_cls_e c);
      return (c == CLS_ALU) || (c == CLS_STORE);
   endfunction

endpackage

// File: rtl/hfc_match.sv
module hfc_match #(
   parameter int IDX_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [IDX_W-1:0] src_idx,
   input  logic             src_used,
   input  logic             prod_ok,
   input  logic [IDX_W-1:0] prod_dest,
   output logic             hit
);
   localparam logic [IDX_W-1:0] ZERO_IDX = '0;

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign hit = src_used && prod_ok && (src_idx == prod_dest) && (src_idx != ZERO_IDX);
      end else begin : g_zero_plain
         assign hit = src_used && prod_ok && (src_idx == prod_dest);
      end
   endgenerate
endmodule

// File: rtl/hfc_stall_unit.sv
module hfc_stall_unit
   import hfc_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter bit ZERO_HARD = 1'b1,
   parameter bit FWD_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  op_cls_e          dec_cls,
   input  logic [IDX_W-1:0] dec_src_a,
   input  logic [IDX_W-1:0] dec_src_b,
   input  logic             ex_valid,
   input  op_cls_e          ex_cls,
   input  logic [IDX_W-1:0] ex_dest,
   input  logic             mem_valid,
   input  op_cls_e          mem_cls,
   input  logic [IDX_W-1:0] mem_dest,
   output logic             stall
);
   logic ex_wr, mem_wr, use_a, use_b;
   logic a_ex, b_ex, a_mem, b_mem;

   assign ex_wr  = ex_valid  && cls_writes_reg(ex_cls);
   assign mem_wr = mem_valid && cls_writes_reg(mem_cls);
   assign use_a  = dec_valid && cls_reads_a(dec_cls);
   assign use_b  = dec_valid && cls_reads_b(dec_cls);

   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_a_ex (
      .src_idx(dec_src_a), .src_used(use_a), .prod_ok(ex_wr), .prod_dest(ex_dest), .hit(a_ex));
   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_b_ex (
      .src_idx(dec_src_b), .src_used(use_b), .prod_ok(ex_wr), .prod_dest(ex_dest), .hit(b_ex));
   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_a_mem (
      .src_idx(dec_src_a), .src_used(use_a), .prod_ok(mem_wr), .prod_dest(mem_dest), .hit(a_mem));
   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_b_mem (
      .src_idx(dec_src_b), .src_used(use_b), .prod_ok(mem_wr), .prod_dest(mem_dest), .hit(b_mem));

   generate
      if (FWD_EN) begin : g_bypass
         logic load_use, store_data;
         // load result not ready until end of memory access
         assign load_use   = (ex_cls == CLS_LOAD) &&
                             (a_ex || (b_ex && (dec_cls == CLS_ALU)));
         // store data must be the decode-time register value
         assign store_data = (dec_cls == CLS_STORE) && (b_ex || b_mem);
         assign stall      = load_use || store_data;
      end else begin : g_interlock
         assign stall = a_ex || b_ex || a_mem || b_mem;
      end
   endgenerate

   // R4: load in execute feeding decode operand A must hold decode
   assert_load_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && (dec_cls != CLS_OTHER) && ex_valid && (ex_cls == CLS_LOAD) &&
       (dec_src_a == ex_dest) && (!ZERO_HARD || (dec_src_a != '0))) |-> stall);

   // R5: store data register still produced in memory stage must hold decode
   assert_store_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && (dec_cls == CLS_STORE) && mem_valid && cls_writes_reg(mem_cls) &&
       (dec_src_b == mem_dest) && (!ZERO_HARD || (dec_src_b != '0))) |-> stall);

   // R11: an empty decode slot never stalls
   assert_invalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !stall);
endmodule

// File: rtl/hfc_sel_unit.sv
module hfc_sel_unit
   import hfc_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter bit ZERO_HARD = 1'b1,
   parameter bit FWD_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_used,
   input  logic [IDX_W-1:0] src_idx,
   input  logic             mem_valid,
   input  op_cls_e          mem_cls,
   input  logic [IDX_W-1:0] mem_dest,
   input  logic             wb_valid,
   input  op_cls_e          wb_cls,
   input  logic [IDX_W-1:0] wb_dest,
   output opnd_sel_e        sel
);
   logic mem_ok, wb_ok, hit_mem, hit_wb;

   // a load in memory access has no result yet; only ALU results bypass from there
   assign mem_ok = mem_valid && (mem_cls == CLS_ALU);
   assign wb_ok  = wb_valid  && cls_writes_reg(wb_cls);

   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_hit_mem (
      .src_idx(src_idx), .src_used(src_used), .prod_ok(mem_ok), .prod_dest(mem_dest), .hit(hit_mem));
   hfc_match #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD)) u_hit_wb (
      .src_idx(src_idx), .src_used(src_used), .prod_ok(wb_ok), .prod_dest(wb_dest), .hit(hit_wb));

   generate
      if (FWD_EN) begin : g_bypass
         always_comb begin
            if (hit_mem)     sel = SEL_FROM_MEM;
            else if (hit_wb) sel = SEL_FROM_WB;
            else             sel = SEL_REGFILE;
         end
      end else begin : g_interlock
         assign sel = SEL_REGFILE;
      end
   endgenerate

   // R6: youngest producer wins when both boundaries match
   assert_mem_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (FWD_EN && src_used && mem_valid && (mem_cls == CLS_ALU) && (src_idx == mem_dest) &&
       (!ZERO_HARD || (src_idx != '0))) |-> (sel == SEL_FROM_MEM));

   // R7: the hardwired zero register is always read from the register file
   assert_zero_no_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HARD && (src_idx == '0)) |-> (sel == SEL_REGFILE));

   // R11: an unused operand stays on the register file path
   assert_unused_regfile_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !src_used |-> (sel == SEL_REGFILE));
endmodule

// File: rtl/hfc_top.sv
module hfc_top
   import hfc_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter bit ZERO_HARD = 1'b1,
   parameter bit FWD_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [1:0]       dec_class,
   input  logic [IDX_W-1:0] dec_src_a,
   input  logic [IDX_W-1:0] dec_src_b,
   input  logic             ex_valid,
   input  logic [1:0]       ex_class,
   input  logic [IDX_W-1:0] ex_dest,
   input  logic [IDX_W-1:0] ex_src_a,
   input  logic [IDX_W-1:0] ex_src_b,
   input  logic             mem_valid,
   input  logic [1:0]       mem_class,
   input  logic [IDX_W-1:0] mem_dest,
   input  logic             wb_valid,
   input  logic [1:0]       wb_class,
   input  logic [IDX_W-1:0] wb_dest,
   output logic             stall_fetch,
   output logic             stall_decode,
   output logic             bubble_ex,
   output logic [1:0]       sel_a,
   output logic [1:0]       sel_b
);
   localparam int NUM_OPND = 2;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx_w
         $error("hfc_top: IDX_W must lie in 1..8");
      end
   endgenerate

   op_cls_e dec_cls, ex_cls, mem_cls, wb_cls;
   logic    hold;

   assign dec_cls = op_cls_e'(dec_class);
   assign ex_cls  = op_cls_e'(ex_class);
   assign mem_cls = op_cls_e'(mem_class);
   assign wb_cls  = op_cls_e'(wb_class);

   hfc_stall_unit #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD), .FWD_EN(FWD_EN)) u_stall (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(dec_valid), .dec_cls(dec_cls), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .ex_valid(ex_valid), .ex_cls(ex_cls), .ex_dest(ex_dest),
      .mem_valid(mem_valid), .mem_cls(mem_cls), .mem_dest(mem_dest),
      .stall(hold));

   assign stall_fetch  = hold;
   assign stall_decode = hold;
   assign bubble_ex    = hold;

   logic [IDX_W-1:0] opnd_idx  [NUM_OPND];
   logic             opnd_used [NUM_OPND];
   opnd_sel_e        opnd_sel  [NUM_OPND];

   // operand A feeds ALU, load and store address; operand B is an ALU input only
   assign opnd_idx[0]  = ex_src_a;
   assign opnd_used[0] = ex_valid && cls_reads_a(ex_cls);
   assign opnd_idx[1]  = ex_src_b;
   assign opnd_used[1] = ex_valid && (ex_cls == CLS_ALU);

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
         hfc_sel_unit #(.IDX_W(IDX_W), .ZERO_HARD(ZERO_HARD), .FWD_EN(FWD_EN)) u_sel (
            .clk(clk), .rst_n(rst_n),
            .src_used(opnd_used[g]), .src_idx(opnd_idx[g]),
            .mem_valid(mem_valid), .mem_cls(mem_cls), .mem_dest(mem_dest),
            .wb_valid(wb_valid), .wb_cls(wb_cls), .wb_dest(wb_dest),
            .sel(opnd_sel[g]));
      end
   endgenerate

   assign sel_a = opnd_sel[0];
   assign sel_b = opnd_sel[1];

   // R8: select code 11 never appears
   assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a != 2'b11) && (sel_b != 2'b11));

   // R5: store data never takes a bypass path
   assert_store_b_regfile_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && (ex_class == 2'b11)) |-> (sel_b == 2'b00));

   // R1: the three hold controls move together
   assert_hold_together_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_fetch == bubble_ex) && (stall_decode == bubble_ex));
endmodule

// File: tb/hfc_top_tb_top.sv
`timescale 1ns/1ps
module hfc_top_tb_top;
   localparam int W = 5;

   typedef struct packed {
      logic         v;
      logic [1:0]   c;
      logic [W-1:0] d;
      logic [W-1:0] s1;
      logic [W-1:0] s2;
      logic [3:0]   id;
   } ins_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   ins_t sD, sE, sM, sW, sF;
   logic stall_fetch, stall_decode, bubble_ex;
   logic [1:0] sel_a, sel_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   ins_t prog [8];

   hfc_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .dec_valid(sD.v), .dec_class(sD.c), .dec_src_a(sD.s1), .dec_src_b(sD.s2),
      .ex_valid(sE.v), .ex_class(sE.c), .ex_dest(sE.d), .ex_src_a(sE.s1), .ex_src_b(sE.s2),
      .mem_valid(sM.v), .mem_class(sM.c), .mem_dest(sM.d),
      .wb_valid(sW.v), .wb_class(sW.c), .wb_dest(sW.d),
      .stall_fetch(stall_fetch), .stall_decode(stall_decode), .bubble_ex(bubble_ex),
      .sel_a(sel_a), .sel_b(sel_b));

   function automatic ins_t mk(logic [1:0] c, int d, int s1, int s2);
      ins_t t;
      t.v = 1'b1; t.c = c; t.d = W'(d); t.s1 = W'(s1); t.s2 = W'(s2); t.id = '0;
      return t;
   endfunction

   // reference model: class 1 = ALU, 2 = load, 3 = store
   function automatic bit produces(ins_t p);
      return p.v && (p.c == 2'd1 || p.c == 2'd2);
   endfunction
   function automatic bit dep(logic [W-1:0] s, ins_t p);
      return produces(p) && (s == p.d) && (s != 0);
   endfunction

   function automatic bit model_hold(ins_t d, ins_t e, ins_t m);
      if (!d.v || d.c == 2'd0) return 0;
      if (e.v && e.c == 2'd2) begin
         if (dep(d.s1, e)) return 1;
         if (d.c == 2'd1 && dep(d.s2, e)) return 1;
      end
      if (d.c == 2'd3 && (dep(d.s2, e) || dep(d.s2, m))) return 1;
      return 0;
   endfunction

   function automatic logic [1:0] model_sel(bit used, logic [W-1:0] s, ins_t m, ins_t w);
      if (!used) return 2'b00;
      if (m.v && m.c == 2'd1 && s == m.d && s != 0) return 2'b01;
      if (dep(s, w)) return 2'b10;
      return 2'b00;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_prog(string tag, int n, int exp_wb, int exp_stalls);
      int pc, cyc, stalls, last_wb;
      bit h;
      ins_t bub;
      bub = '0;
      @(posedge clk); #1;
      sD = bub; sE = bub; sM = bub; sW = bub;
      for (int i = 0; i < n; i++) prog[i].id = 4'(i);
      sF = prog[0]; pc = 1; cyc = 1; stalls = 0; last_wb = 0;
      for (int k = 0; k < 40; k++) begin
         if (sW.v && sW.id == 4'(n - 1)) last_wb = cyc;
         @(negedge clk);
         h = model_hold(sD, sE, sM);
         if (h) stalls++;
         check({tag, " R1 hold controls"}, {29'd0, stall_fetch, stall_decode, bubble_ex}, {29'd0, h, h, h});
         check({tag, " R2/R3 sel_a"}, {30'd0, sel_a},
               {30'd0, model_sel(sE.v && sE.c != 2'd0, sE.s1, sM, sW)});
         check({tag, " R5 sel_b"}, {30'd0, sel_b},
               {30'd0, model_sel(sE.v && sE.c == 2'd1, sE.s2, sM, sW)});
         @(posedge clk); #1;
         sW = sM; sM = sE;
         if (h) begin
            sE = sD; sE.v = 1'b0;          // bubble keeps stale fields (R11)
         end else begin
            sE = sD; sD = sF;
            if (pc < n) begin sF = prog[pc]; pc++; end
            else sF = bub;
         end
         cyc++;
         if (!sF.v && !sD.v && !sE.v && !sM.v && !sW.v) break;
      end
      check({tag, " stall cycles"}, 32'(stalls), 32'(exp_stalls));
      check({tag, " write-back cycle of last"}, 32'(last_wb), 32'(exp_wb));
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      sD = '0; sE = '0; sM = '0; sW = '0; sF = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset hold", {29'd0, stall_fetch, stall_decode, bubble_ex}, 32'd0);
      check("R8 reset selects", {28'd0, sel_a, sel_b}, 32'd0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R9, R4, R3, R2: load r1; r1=r1+r1; r2=r2-r1
      prog[0] = mk(2, 1, 5, 0); prog[1] = mk(1, 1, 1, 1); prog[2] = mk(1, 2, 2, 1);
      run_prog("R9", 3, 8, 1);

      // R5: ALU r3 then store data r3 waits two cycles
      prog[0] = mk(1, 3, 4, 4); prog[1] = mk(3, 0, 6, 3);
      run_prog("R5 alu->store data", 2, 8, 2);

      // R5/R4: load r3 then store data r3
      prog[0] = mk(2, 3, 1, 0); prog[1] = mk(3, 0, 6, 3);
      run_prog("R5 load->store data", 2, 8, 2);

      // R4: load r3 then store address r3
      prog[0] = mk(2, 3, 1, 0); prog[1] = mk(3, 0, 3, 7);
      run_prog("R4 load->store addr", 2, 7, 1);

      // R10: ALU r3 then store address r3, bypassed
      prog[0] = mk(1, 3, 1, 2); prog[1] = mk(3, 0, 3, 4);
      run_prog("R10 alu->store addr", 2, 6, 0);

      // R6: two producers of r3 then consumer
      prog[0] = mk(1, 3, 1, 1); prog[1] = mk(1, 3, 3, 3); prog[2] = mk(1, 5, 3, 2);
      run_prog("R6 priority", 3, 7, 0);

      // R7: load into r0 then use r0
      prog[0] = mk(2, 0, 1, 0); prog[1] = mk(1, 2, 0, 0);
      run_prog("R7 zero reg", 2, 6, 0);

      // R11: class-other entry with a dest field
      prog[0] = mk(0, 4, 1, 1); prog[1] = mk(1, 5, 4, 4);
      run_prog("R11 other class", 2, 6, 0);

      // R3: producer two ahead on operand B
      prog[0] = mk(1, 6, 1, 1); prog[1] = mk(1, 7, 2, 2); prog[2] = mk(1, 8, 2, 6);
      run_prog("R3 wb bypass", 3, 7, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule